// File: doc/BRIEF.md
# Legacy Memory Window Attribute Decoder

This block steers every access that falls in the legacy area between 0xA0000 and 0xFFFFF. It looks at the physical address, the access direction and the system-management state, and picks one of three targets: main DRAM, a read-only DRAM shadow, or the legacy expansion bus. Addresses outside that window always go to DRAM.

The routing comes from a small set of configuration bytes written through a simple byte-wide write port. The topmost 64 KB block is controlled by one 2-bit attribute. The expansion-ROM area below it is split into twelve 16 KB segments, and each segment has its own 2-bit attribute packed as a nibble. The 128 KB video hole is controlled by a system-management RAM control byte. A write that targets a read-only segment is refused: the write-block flag rises and no target is selected.

The target decision is combinational from the address inputs and the stored configuration. A configuration write becomes visible on the cycle after the clock edge that captures it.

Top module: `legacy_window_decoder`

## Requirements
- R1: After reset, every attribute field is 0 and the control byte at offset 0x72 holds 0x02. As a result, every address from 0xA0000 to 0xFFFFF selects the legacy bus.
- R2: Any address below 0xA0000 or at 0x100000 and above selects DRAM, for reads and for writes, whatever the configuration.
- R3: The range 0xF0000–0xFFFFF uses the attribute in bits [5:4] of the byte at offset 0x59. The other bits of that byte have no effect.
- R4: Segment i (0..11) covers 0xC0000 + i·0x4000 up to 16 KB above that. Its attribute is in the byte at offset 0x5A + (i>>1): bits [1:0] for even i and bits [5:4] for odd i. Bits [3:2] and [7:6] have no effect.
- R5: Attribute value 3 selects DRAM for both reads and writes.
- R6: Attribute value 1 selects the read-only shadow for reads. A write to such a region raises wr_block and selects no target (tgt_sel = 000).
- R7: Attribute values 0 and 2 select the legacy bus for reads and writes.
- R8: When bit 6 of the byte at offset 0x72 is set, the range 0xA0000–0xBFFFF selects DRAM, whether or not system-management mode is active.
- R9: When bit 6 of offset 0x72 is clear and bit 3 is set, 0xA0000–0xBFFFF selects DRAM only while smm_active is high. Otherwise that range selects the legacy bus.
- R10: A configuration write changes the decode from the cycle after the capturing clock edge, not before. Writes to any offset other than 0x59–0x5F and 0x72 leave the decode unchanged.
- R11: tgt_sel is encoded as bit 0 = DRAM, bit 1 = read-only shadow, bit 2 = legacy bus. Exactly one bit is set, except during a blocked write, when all bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration byte write strobe |
| cfg_wr_addr | input | CFG_AW | Configuration byte offset |
| cfg_wr_data | input | 8 | Configuration byte value |
| acc_addr | input | ADDR_W | Physical address of the access |
| acc_is_write | input | 1 | 1 for a write access, 0 for a read |
| smm_active | input | 1 | System-management mode is active |
| tgt_sel | output | 3 | One-hot target: bit 0 DRAM, bit 1 read-only shadow, bit 2 legacy bus |
| wr_block | output | 1 | Write refused because the region is read-only |

## Verification
The bench probes the first and last address of every segment and of the 0xF0000 block, and the addresses just outside the window on both sides. A decoder whose segment index or window bounds are off by one then routes a neighbour's attribute or spills into DRAM space.

Each segment gets a different attribute, and the unused bits of every attribute byte are set. A design that swaps the even and odd nibbles, or reads the wrong bit pair, produces visibly wrong targets.

The video hole is tried under all combinations of the two control bits and system-management mode, so a design that ignores smm_active or treats bit 3 alone as an enable fails. Writes to offsets next to the mapped ones, and a probe taken just before the capturing edge, catch a design that decodes too wide or updates combinationally.

// File: rtl/legacy_window_decoder.sv
module legacy_window_decoder #(
  parameter int ADDR_W = 32,
  parameter int CFG_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [CFG_AW-1:0] cfg_wr_addr,
  input  logic [7:0]        cfg_wr_data,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_is_write,
  input  logic              smm_active,
  output logic [2:0]        tgt_sel,
  output logic              wr_block
);

  localparam int NSEG  = 12;
  localparam int NBYTE = NSEG / 2;
  localparam logic [CFG_AW-1:0] OFF_HI    = CFG_AW'(8'h59);
  localparam logic [CFG_AW-1:0] OFF_SEG0  = CFG_AW'(8'h5A);
  localparam logic [CFG_AW-1:0] OFF_SMRAM = CFG_AW'(8'h72);
  localparam logic [7:0] SMRAM_RST = 8'h02;
  localparam logic [2:0] SEL_DRAM = 3'b001;
  localparam logic [2:0] SEL_ROM  = 3'b010;
  localparam logic [2:0] SEL_BUS  = 3'b100;
  localparam logic [2:0] SEL_NONE = 3'b000;

  logic [1:0]            hi_attr;
  logic [NSEG-1:0][1:0]  seg_q;
  logic [7:0]            smram_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                               hi_attr <= 2'b00;
    else if (cfg_wr_en && cfg_wr_addr == OFF_HI) hi_attr <= cfg_wr_data[5:4];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                  smram_q <= SMRAM_RST;
    else if (cfg_wr_en && cfg_wr_addr == OFF_SMRAM) smram_q <= cfg_wr_data;

  for (genvar k = 0; k < NBYTE; k++) begin : g_seg_byte
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        seg_q[2*k]   <= 2'b00;
        seg_q[2*k+1] <= 2'b00;
      end else if (cfg_wr_en && cfg_wr_addr == OFF_SEG0 + CFG_AW'(k)) begin
        seg_q[2*k]   <= cfg_wr_data[1:0];
        seg_q[2*k+1] <= cfg_wr_data[5:4];
      end
  end

  wire        low_mb   = (acc_addr >> 20) == '0;
  wire [3:0]  blk64    = acc_addr[19:16];
  wire        in_video = low_mb && (blk64 == 4'hA || blk64 == 4'hB);
  wire        in_hi    = low_mb && blk64 == 4'hF;
  wire        in_seg   = low_mb && (blk64 == 4'hC || blk64 == 4'hD || blk64 == 4'hE);
  wire [3:0]  seg_idx  = acc_addr[17:14];
  wire        vid_dram = smram_q[6] || (smm_active && smram_q[3]);

  logic [1:0] seg_attr;
  always_comb begin
    seg_attr = 2'b00;
    for (int i = 0; i < NSEG; i++)
      if (seg_idx == 4'(i)) seg_attr = seg_q[i];
  end

  wire [1:0] attr = in_hi ? hi_attr : seg_attr;

  always_comb begin
    tgt_sel  = SEL_DRAM;
    wr_block = 1'b0;
    if (in_video)
      tgt_sel = vid_dram ? SEL_DRAM : SEL_BUS;
    else if (in_hi || in_seg)
      case (attr)
        2'd3: tgt_sel = SEL_DRAM;
        2'd1: if (acc_is_write) begin
                tgt_sel  = SEL_NONE;
                wr_block = 1'b1;
              end else tgt_sel = SEL_ROM;
        default: tgt_sel = SEL_BUS;
      endcase
  end

endmodule

module legacy_window_decoder_chk #(
  parameter int ADDR_W = 32,
  parameter int CFG_AW = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr_en,
  input logic [CFG_AW-1:0] cfg_wr_addr,
  input logic [7:0]        cfg_wr_data,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              acc_is_write,
  input logic [2:0]        tgt_sel,
  input logic              wr_block,
  input logic [7:0]        smram_q
);
  localparam logic [CFG_AW-1:0] OFF_SMRAM = CFG_AW'(8'h72);

  // R11
  onehot_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_block |-> $countones(tgt_sel) == 1);

  // R6
  blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_block |-> (tgt_sel == 3'b000 && acc_is_write));

  // R2
  outside_dram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_addr >> 20) != '0 |-> (tgt_sel == 3'b001 && !wr_block));

  // R1
  smram_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> smram_q == 8'h02);

  // R10
  smram_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && cfg_wr_addr == OFF_SMRAM) |=> smram_q == $past(cfg_wr_data));

  // R10
  smram_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr_en && cfg_wr_addr == OFF_SMRAM) |=> $stable(smram_q));
endmodule

bind legacy_window_decoder legacy_window_decoder_chk #(.ADDR_W(ADDR_W), .CFG_AW(CFG_AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
  .cfg_wr_data(cfg_wr_data), .acc_addr(acc_addr), .acc_is_write(acc_is_write),
  .tgt_sel(tgt_sel), .wr_block(wr_block), .smram_q(smram_q)
);

// File: tb/legacy_window_decoder_tb_top.sv
module legacy_window_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [7:0]  cfg_wr_addr = '0;
  logic [7:0]  cfg_wr_data = '0;
  logic [31:0] acc_addr = '0;
  logic        acc_is_write = 1'b0;
  logic        smm_active = 1'b0;
  logic [2:0]  tgt_sel;
  logic        wr_block;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] m59 = 8'h00;
  logic [7:0] m72 = 8'h02;
  logic [7:0] m5x [6];

  legacy_window_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
    .cfg_wr_data(cfg_wr_data), .acc_addr(acc_addr), .acc_is_write(acc_is_write),
    .smm_active(smm_active), .tgt_sel(tgt_sel), .wr_block(wr_block)
  );

  always #5 clk = ~clk;

  function automatic logic [3:0] model_exp(input logic [31:0] a, input logic w, input logic s);
    logic [1:0] at;
    int i;
    if (a < 32'hA0000 || a >= 32'h100000) return 4'b0001;
    if (a < 32'hC0000) return (m72[6] || (s && m72[3])) ? 4'b0001 : 4'b0100;
    if (a >= 32'hF0000) at = m59[5:4];
    else begin
      i = int'((a - 32'hC0000) / 32'h4000);
      at = (i % 2 == 1) ? m5x[i/2][5:4] : m5x[i/2][1:0];
    end
    case (at)
      2'd3: return 4'b0001;
      2'd1: return w ? 4'b1000 : 4'b0010;
      default: return 4'b0100;
    endcase
  endfunction

  task automatic probe(input logic [31:0] a, input logic w, input logic s, input string tag);
    logic [3:0] exp;
    acc_addr = a; acc_is_write = w; smm_active = s;
    #1;
    exp = model_exp(a, w, s);
    checks++;
    if ({wr_block, tgt_sel} !== exp) begin
      fails++;
      $display("FAIL %s addr=%h wr=%0d smm=%0d actual=%b expected=%b", tag, a, w, s, {wr_block, tgt_sel}, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] off, input logic [7:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_addr = off; cfg_wr_data = d;
    @(posedge clk);
    if (off == 8'h59) m59 = d;
    if (off == 8'h72) m72 = d;
    if (off >= 8'h5A && off <= 8'h5F) m5x[off - 8'h5A] = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic t_reset();
    probe(32'hA0000, 0, 0, "R1 video read");
    probe(32'hBFFFF, 1, 1, "R1 video write smm");
    probe(32'hC0000, 0, 0, "R1 seg0");
    probe(32'hEFFFF, 1, 0, "R1 seg11");
    probe(32'hF0000, 0, 0, "R1 R11 high block");
    probe(32'hFFFFF, 1, 0, "R1 high top");
  endtask

  task automatic t_outside();
    probe(32'h9FFFF, 0, 0, "R2 below read");
    probe(32'h9FFFF, 1, 1, "R2 below write");
    probe(32'h100000, 1, 0, "R2 above write");
    probe(32'h000F0000 | 32'h10000000, 0, 0, "R2 high alias");
    probe(32'h0, 0, 0, "R2 zero");
  endtask

  task automatic t_high();
    cfg_write(8'h59, 8'h30);
    probe(32'hF0000, 0, 0, "R3 R5 attr3 read");
    probe(32'hFFFFF, 1, 0, "R3 R5 attr3 write");
    cfg_write(8'h59, 8'hDF);
    probe(32'hF8000, 0, 0, "R3 R6 attr1 read");
    probe(32'hF8000, 1, 0, "R3 R6 attr1 write blocked");
    cfg_write(8'h59, 8'hCF);
    probe(32'hF0000, 0, 0, "R3 R7 attr0 extra bits");
    cfg_write(8'h59, 8'h20);
    probe(32'hFFFFF, 1, 0, "R3 R7 attr2");
  endtask

  task automatic t_segments();
    logic [1:0] at [12] = '{2'd3, 2'd1, 2'd0, 2'd2, 2'd1, 2'd3, 2'd3, 2'd0, 2'd2, 2'd1, 2'd3, 2'd1};
    for (int k = 0; k < 6; k++)
      cfg_write(8'h5A + 8'(k), {2'b11, at[2*k+1], 2'b11, at[2*k]});
    for (int i = 0; i < 12; i++) begin
      logic [31:0] base = 32'hC0000 + 32'(i) * 32'h4000;
      probe(base, 0, 0, "R4 seg start read");
      probe(base, 1, 0, "R4 R5 R6 R7 seg start write");
      probe(base + 32'h3FFF, 0, 1, "R4 seg end read");
      probe(base + 32'h3FFF, 1, 1, "R4 seg end write");
    end
  endtask

  task automatic t_video();
    cfg_write(8'h72, 8'h40);
    probe(32'hA0000, 0, 0, "R8 bit6 no smm");
    probe(32'hBFFFF, 1, 1, "R8 bit6 smm");
    cfg_write(8'h72, 8'h08);
    probe(32'hA0000, 0, 1, "R9 bit3 smm");
    probe(32'hB0000, 1, 0, "R9 bit3 no smm");
    cfg_write(8'h72, 8'hB7);
    probe(32'hA0000, 0, 1, "R9 neither bit smm");
    cfg_write(8'h72, 8'h48);
    probe(32'hBFFFF, 0, 0, "R8 both bits");
  endtask

  task automatic t_ignore();
    cfg_write(8'h58, 8'hFF);
    cfg_write(8'h60, 8'hFF);
    cfg_write(8'h71, 8'hFF);
    cfg_write(8'h73, 8'hFF);
    cfg_write(8'hD9, 8'h10);
    probe(32'hF0000, 1, 0, "R10 ignored high");
    probe(32'hC4000, 1, 0, "R10 ignored seg1");
    probe(32'hEC000, 0, 0, "R10 ignored seg11");
    probe(32'hA0000, 0, 0, "R10 ignored video");
  endtask

  task automatic t_latency();
    cfg_write(8'h72, 8'h00);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_addr = 8'h72; cfg_wr_data = 8'h40;
    probe(32'hA0000, 0, 0, "R10 before edge");
    @(posedge clk);
    m72 = 8'h40;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    probe(32'hA0000, 0, 0, "R10 after edge");
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    for (int k = 0; k < 6; k++) m5x[k] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_outside();
    t_high();
    t_segments();
    t_video();
    t_ignore();
    t_latency();
    done = 1;
    finish_run();
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end
endmodule